// File: doc/BRIEF.md
# Serial Converter Frame Sequencer

This block is the digital side of a two-channel, 8-bit serial converter. It runs on a system clock and treats the host's select, serial clock and serial data lines as synchronous inputs. Lowering the select line does not start anything on its own. A frame begins with the first high data bit that is sampled while the block is free. That bit is the leading bit of an 8-bit control word, and the bit that follows it picks the channel. Partway through the control word, a timed acquisition window opens. The conversion phase follows it directly. The 8-bit code of the chosen channel is then shifted out MSB first, one bit per falling serial-clock edge.

Two timing variants are available. With host-clocked timing, acquisition and conversion are both counted in serial-clock periods, and a frame can repeat every 10 serial clocks. With self-timed timing, acquisition is longer and conversion runs for a fixed number of system clocks. The next frame's start bit may arrive while the previous result is still being shifted out, but only once a set result bit has been driven. The sampled codes arrive on two parallel ports.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, with the select line high, `ser_out` is 0 and `ser_oe` is 0; no frame is in progress.
- R2: Lowering `sel_n` with `ser_in` low starts no frame; a frame starts only on a rising `ser_clk` edge with `sel_n` low, the block free, and `ser_in` high (this is bit 1 of the frame).
- R3: The data bit sampled on the second rising edge of a frame selects the channel: 0 loads `smp_ch0`, 1 loads `smp_ch1`.
- R4: With `int_timing` low at the start bit, acquisition covers falling edges 4 to 6 of the frame, conversion covers falling edges 6 to 8, and D7 appears on `ser_out` after falling edge 8.
- R5: With `int_timing` high at the start bit, acquisition covers falling edges 4 to 8. Conversion then lasts CONV_CYCLES system clocks. D7 appears after the first falling edge that comes once that count is complete.
- R6: The result leaves MSB first, one new bit after each falling `ser_clk` edge. `ser_out` returns to 0 on the falling edge after D0.
- R7: In host-clocked timing, a high data bit sampled before D5 has been driven is not a start bit. One sampled after D5 is, so frames of 10 serial clocks can run back to back.
- R8: In self-timed timing, the same overlap rule applies with D4 in place of D5.
- R9: Back-to-back frames of 16 serial clocks each produce one correct result per frame.
- R10: Raising `sel_n` at any point ends the frame: `ser_oe` falls, `ser_out` reads 0, and a fresh start bit is needed.
- R11: `int_timing` is taken at the start bit; changing it during a frame has no effect on that frame.
- R12: `ser_out` changes only after a falling `ser_clk` edge or a rise of `sel_n`.
- R13: `ser_in` is sampled only at rising `ser_clk` edges; a high pulse between rising edges starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Host select, active low |
| ser_clk | input | 1 | Serial clock from the host, synchronous to `clk` |
| ser_in | input | 1 | Serial control data from the host |
| int_timing | input | 1 | 1 selects self-timed conversion, 0 host-clocked |
| smp_ch0 | input | DATA_W | Sampled code of channel 0 |
| smp_ch1 | input | DATA_W | Sampled code of channel 1 |
| ser_out | output | 1 | Serial result, MSB first |
| ser_oe | output | 1 | Output enable for `ser_out` (high while selected) |

## Verification
The in-line properties check the following on every cycle:
- the abort path;
- that `ser_out` moves only on falling serial edges;
- that a new result never lands on top of one still being shifted;
- that the channel is captured before the load;
- that the latched timing mode holds steady through a frame.

Only the bench's scenarios can show the exact falling edge on which D7 appears in each mode. The same applies to whether a high bit just before or just after the D5 or D4 boundary opens a frame, and to the channel and bit order of each result. The bench checks these with a behavioural model that is compared against the outputs on every clock.

// File: rtl/sfs_pkg.sv
// Shared types of the frame sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sfs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CTRL = 2'd1,
        PH_ACQ  = 2'd2,
        PH_CONV = 2'd3
    } phase_t;
endpackage

// File: rtl/sfs_edge_det.sv
// Serial clock edge detector.
// Does: flags rising and falling edges of the host serial clock, one clk wide.
// Assumes: ser_clk is already synchronous to clk and idles low out of reset.
module sfs_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    output logic rise,
    output logic fall
);
    logic prev_q;

    // Remember the serial clock level of the previous system cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= ser_clk;
    end

    // Edge flags from the current and previous levels.
    always_comb begin
        rise = ser_clk & ~prev_q;
        fall = ~ser_clk & prev_q;
    end
endmodule

// File: rtl/sfs_seq.sv
// Frame phase sequencer.
// Does: detects the start bit, captures the channel bit, counts falling
// edges through acquisition and conversion, and pulses load_o when the
// result is ready (always on a falling edge).
// Assumes: gate_i tells whether the result shifter allows a new start bit.
module sfs_seq #(
    parameter int CONV_CYCLES = 12,
    parameter int ACQ_BEGIN   = 4,
    parameter int ACQ_LEN_EXT = 2,
    parameter int ACQ_LEN_INT = 4,
    parameter int CONV_LEN_EXT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic rise,
    input  logic fall,
    input  logic ser_in,
    input  logic int_timing,
    input  logic gate_i,
    output logic load_o,
    output logic ch_o,
    output logic int_m_o
);
    import sfs_pkg::*;

    localparam int FW = 4;
    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic [FW-1:0] F_ACQ  = FW'(ACQ_BEGIN);
    localparam logic [FW-1:0] F_CONV_EXT = FW'(ACQ_BEGIN + ACQ_LEN_EXT);
    localparam logic [FW-1:0] F_CONV_INT = FW'(ACQ_BEGIN + ACQ_LEN_INT);
    localparam logic [FW-1:0] F_RES_EXT  = FW'(ACQ_BEGIN + ACQ_LEN_EXT + CONV_LEN_EXT);
    localparam logic [CW-1:0] CC_DONE = CW'(CONV_CYCLES);

    phase_t        st;
    logic [FW-1:0] fcnt;
    logic [FW-1:0] fcnt_nx;
    logic [CW-1:0] cc;
    logic          ch_wait;
    logic          conv_done;

    // Next falling-edge count and end-of-conversion condition.
    always_comb begin
        fcnt_nx   = fcnt + 1'b1;
        conv_done = int_m_o ? (cc == CC_DONE) : (fcnt_nx == F_RES_EXT);
        load_o    = (st == PH_CONV) && fall && !sel_n && conv_done;
    end

    // Phase register, counters, channel and mode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= PH_IDLE;
            fcnt    <= '0;
            cc      <= '0;
            ch_wait <= 1'b0;
            ch_o    <= 1'b0;
            int_m_o <= 1'b0;
        end else if (sel_n) begin
            st      <= PH_IDLE;
            ch_wait <= 1'b0;
        end else if (st == PH_IDLE) begin
            if (rise && ser_in && gate_i) begin
                st      <= PH_CTRL;
                fcnt    <= '0;
                int_m_o <= int_timing;
                ch_wait <= 1'b1;
            end
        end else begin
            if (rise && ch_wait) begin
                ch_o    <= ser_in;
                ch_wait <= 1'b0;
            end
            if (fall) fcnt <= fcnt_nx;
            case (st)
                PH_CTRL: if (fall && fcnt_nx == F_ACQ) st <= PH_ACQ;
                PH_ACQ: if (fall && fcnt_nx == (int_m_o ? F_CONV_INT : F_CONV_EXT)) begin
                    st <= PH_CONV;
                    cc <= '0;
                end
                PH_CONV: begin
                    if (int_m_o && cc != CC_DONE) cc <= cc + 1'b1;
                    if (fall && conv_done) st <= PH_IDLE;
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> st == PH_IDLE);
    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_IDLE) |=> $stable(int_m_o));
    // R3
    ch_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> !ch_wait);
endmodule

// File: rtl/sfs_shift.sv
// Result shifter.
// Does: loads a code on load_i, drives it MSB first, one bit per falling
// serial edge, and reports when a new start bit may be accepted.
// Assumes: load_i is only high together with fall.
module sfs_shift #(
    parameter int DATA_W   = 8,
    parameter int GATE_EXT = 5,
    parameter int GATE_INT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              fall,
    input  logic              load_i,
    input  logic              int_m,
    input  logic [DATA_W-1:0] data_i,
    output logic              bit_o,
    output logic              gate_o
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST   = CW'(DATA_W);
    localparam logic [CW-1:0] THR_E  = CW'(DATA_W - GATE_EXT);
    localparam logic [CW-1:0] THR_I  = CW'(DATA_W - GATE_INT);

    logic [DATA_W-1:0] sr;
    logic [CW-1:0]     cnt;
    logic              act;

    // Shift register, driven-bit count and active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
            act <= 1'b0;
        end else if (sel_n) begin
            cnt <= '0;
            act <= 1'b0;
        end else if (fall) begin
            if (load_i) begin
                sr  <= data_i;
                cnt <= CW'(1);
                act <= 1'b1;
            end else if (act) begin
                if (cnt == LAST) begin
                    act <= 1'b0;
                end else begin
                    sr  <= sr << 1;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Serial bit and start-bit gate.
    always_comb begin
        bit_o  = act & sr[DATA_W-1];
        gate_o = !act || (cnt >= (int_m ? THR_I : THR_E));
    end

    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !act);
    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !act);
    // R12
    out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !sel_n) |=> $stable(bit_o));
    // R6
    low_after_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cnt == LAST && fall && !load_i && !sel_n) |=> !bit_o);
endmodule

// File: rtl/adc_frame_seq.sv
// Top of the serial converter frame sequencer.
// Does: ties the edge detector, phase sequencer and result shifter together
// and selects the channel code to load.
// Assumes: all host lines are synchronous to clk; the codes are stable.
module adc_frame_seq #(
    parameter int DATA_W      = 8,
    parameter int CONV_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              ser_clk,
    input  logic              ser_in,
    input  logic              int_timing,
    input  logic [DATA_W-1:0] smp_ch0,
    input  logic [DATA_W-1:0] smp_ch1,
    output logic              ser_out,
    output logic              ser_oe
);
    logic rise, fall, load, ch, int_m, gate;
    logic [DATA_W-1:0] code;

    sfs_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .rise(rise), .fall(fall)
    );

    sfs_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rise(rise), .fall(fall),
        .ser_in(ser_in), .int_timing(int_timing), .gate_i(gate),
        .load_o(load), .ch_o(ch), .int_m_o(int_m)
    );

    // Channel code chosen by the captured control bit.
    always_comb begin
        code   = ch ? smp_ch1 : smp_ch0;
        ser_oe = ~sel_n;
    end

    sfs_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .fall(fall), .load_i(load),
        .int_m(int_m), .data_i(code), .bit_o(ser_out), .gate_o(gate)
    );
endmodule

// File: tb/adc_frame_seq_bench.sv
module adc_frame_seq_bench;
    localparam int PER  = 10;
    localparam int HALF = 4;
    localparam int CONV = 12;

    logic clk = 0, rst_n = 0, sel_n = 1, sck = 0, sdi = 0, int_t = 0;
    logic [7:0] s0 = 8'hA5, s1 = 8'h3C;
    logic dout, doe;
    int compared = 0, mismatched = 0, cyc = 0;
    string cur_req = "R1";

    adc_frame_seq u_adc_frame_seq (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(sck), .ser_in(sdi),
        .int_timing(int_t), .smp_ch0(s0), .smp_ch1(s1),
        .ser_out(dout), .ser_oe(doe)
    );

    always #(PER/2) clk = ~clk;

    // Behavioural reference model
    int m_prev, m_busy, m_fc, m_int, m_ch, m_chw, m_conv, m_cc, m_act, m_drv;
    logic [7:0] m_bits;
    logic m_out;
    initial begin
        m_prev = 0; m_busy = 0; m_fc = 0; m_int = 0; m_ch = 0; m_chw = 0;
        m_conv = 0; m_cc = 0; m_act = 0; m_drv = 0; m_bits = 0; m_out = 0;
    end

    always @(posedge clk) begin
        bit rise, fall, ld;
        if (!rst_n) begin
            m_prev = 0; m_busy = 0; m_fc = 0; m_int = 0; m_ch = 0; m_chw = 0;
            m_conv = 0; m_cc = 0; m_act = 0; m_drv = 0; m_out = 0;
        end else begin
            rise = sck && (m_prev == 0);
            fall = !sck && (m_prev == 1);
            m_prev = sck;
            ld = 0;
            if (sel_n) begin
                m_busy = 0; m_chw = 0; m_act = 0; m_drv = 0; m_out = 0;
            end else begin
                if (m_busy == 0) begin
                    if (rise && sdi && (m_act == 0 || m_drv >= (m_int != 0 ? 4 : 3))) begin
                        m_busy = 1; m_fc = 0; m_int = int_t; m_chw = 1; m_conv = 0;
                    end
                end else begin
                    if (rise && m_chw != 0) begin m_ch = sdi; m_chw = 0; end
                    if (m_conv != 0 && m_int != 0) begin
                        if (fall && m_cc >= CONV) ld = 1;
                        if (m_cc < CONV) m_cc++;
                    end
                    if (fall) begin
                        m_fc++;
                        if (m_int == 0 && m_fc == 8) ld = 1;
                        if (m_int != 0 && m_fc == 8 && m_conv == 0) begin
                            m_conv = 1; m_cc = 0;
                        end
                    end
                    if (ld) begin m_busy = 0; m_conv = 0; end
                end
                if (fall) begin
                    if (ld) begin
                        m_bits = (m_ch != 0) ? s1 : s0;
                        m_drv = 1; m_act = 1; m_out = m_bits[7];
                    end else if (m_act != 0) begin
                        if (m_drv == 8) begin m_act = 0; m_out = 0; end
                        else begin m_out = m_bits[7 - m_drv]; m_drv++; end
                    end
                end
            end
        end
    end

    // Compare on every clock, away from the edge
    always @(posedge clk) begin
        #1;
        compared++;
        if (dout !== m_out || doe !== !sel_n) begin
            mismatched++;
            $display("FAIL %s at %0t: ser_out=%b ser_oe=%b expected %b %b",
                     cur_req, $time, dout, doe, m_out, !sel_n);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog (all R) actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic bitc(input logic b);
        sck = 0; sdi = b;
        repeat (HALF) @(negedge clk);
        sck = 1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) bitc(1'b0);
    endtask

    task automatic frame(input int len, input logic ch);
        bitc(1'b1); bitc(ch);
        zeros(len - 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state with select high
        cur_req = "R1";
        compared++;
        if (dout !== 1'b0 || doe !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 ser_out=%b ser_oe=%b expected 0 0", dout, doe);
        end
        rst_n = 1;
        repeat (4) @(negedge clk);

        cur_req = "R2 R13";
        sel_n = 0;
        repeat (6) @(negedge clk);
        zeros(4);
        sck = 0; sdi = 1; repeat (3) @(negedge clk); sdi = 0;
        repeat (HALF) @(negedge clk);
        zeros(4);

        cur_req = "R3 R4 R6 R12";
        frame(2, 1'b0); zeros(18);
        frame(2, 1'b1); zeros(18);

        cur_req = "R5";
        int_t = 1;
        frame(2, 1'b0); zeros(22);
        int_t = 0;

        cur_req = "R7";
        s0 = 8'h96; s1 = 8'h5B;
        frame(10, 1'b0); frame(10, 1'b1); frame(10, 1'b0); zeros(12);
        bitc(1'b1); bitc(1'b1); zeros(7); bitc(1'b1); zeros(14);

        cur_req = "R8";
        int_t = 1;
        frame(13, 1'b1); frame(13, 1'b0); frame(12, 1'b1); zeros(24);
        int_t = 0;

        cur_req = "R9";
        s0 = 8'h01; s1 = 8'hFE;
        frame(16, 1'b1); frame(16, 1'b0); frame(16, 1'b1); zeros(10);

        cur_req = "R10";
        frame(10, 1'b1);
        sel_n = 1; repeat (6) @(negedge clk); sel_n = 0;
        zeros(12);
        bitc(1'b1); bitc(1'b0); zeros(3);
        sel_n = 1; repeat (5) @(negedge clk); sel_n = 0;
        zeros(14);

        cur_req = "R11";
        bitc(1'b1); bitc(1'b1); int_t = 1; zeros(18); int_t = 0;
        int_t = 1; bitc(1'b1); int_t = 0; bitc(1'b0); zeros(22);

        sel_n = 1;
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule